// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This block sits between a card host's command and data engines and the processor's interrupt line. Each engine reports an event as a single-cycle pulse on its own input. The block captures each pulse into a sticky raw status bit. The bit stays set until software clears it by writing a 1 to it. A software-written mask register selects which raw bits may reach the processor. The AND of the raw and mask registers can be read back as a masked status register. When any masked bit is set and the global enable input is high, the block drives a single interrupt output.

Two summary outputs group the masked events into classes. One class is failures: response and data CRC errors, response and data timeouts, FIFO run errors, hardware lock, start-bit and end-bit errors, and response errors. The other class is completions: command done, data over, auto-command done and voltage change done. A request sequencer watching these two lines can end a transfer at once on a failure, or finish it normally on a completion, without decoding the full status word.

The register bus is 32 bits wide. Writes take effect on the clock edge. Reads are combinational from the current register state.

Top module: `card_irq_status`

## Requirements
- R1: While reset is low, and right after it is released, the raw status and mask registers read 0 and `irq_o`, `err_sum_o` and `done_sum_o` are low.
- R2: An event pulse on an implemented bit sets that raw status bit on the next clock edge. The bit stays set after the pulse ends. Implemented bits are: 1 response error, 2 command done, 3 data over, 4 TX request, 5 RX request, 6 response CRC error, 7 data CRC error, 8 response timeout, 9 data timeout, 10 voltage change done, 11 FIFO run error, 12 hardware locked, 13 start-bit error, 14 auto-command done, 15 end-bit error, 16 SDIO interrupt, 30 card insert, 31 card remove.
- R3: A write to offset 0x38 clears every raw bit whose write-data bit is 1 and leaves the raw bits whose write-data bit is 0 unchanged. For example, 0x0000FFFF clears bits 0 to 15.
- R4: When an event pulse and a clearing write to the same raw bit arrive in the same cycle, the bit is set after that edge.
- R5: A read of offset 0x34 returns the raw status ANDed with the mask.
- R6: A write to offset 0x30 loads the mask. A read of 0x30 returns it, with unimplemented bit positions reading 0.
- R7: `irq_o` is high exactly when the masked status is nonzero and `irq_en` is high.
- R8: `err_sum_o` is the OR of masked status bits 1, 6, 7, 8, 9, 11, 12, 13 and 15.
- R9: `done_sum_o` is the OR of masked status bits 2, 3, 10 and 14.
- R10: Unimplemented bit positions (0 and 17 to 29) never become set, whatever the event input carries.
- R11: Writes to offset 0x34 or to any unmapped offset change no register. Reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Global interrupt enable |
| evt_i | input | 32 | Event pulses, one per status bit position |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request |
| err_sum_o | output | 1 | Failure-class summary of masked status |
| done_sum_o | output | 1 | Completion-class summary of masked status |

## Verification
The bench targets the cycle in which a clearing write and a new event land on the same bit. A design that let the clear win would silently lose a completion or an error. It also walks a pulse across all 32 positions. A design with a wrong implemented-bit map would show phantom bits at 0 or 17 to 29, or drop a card-insert event. Single events in each summary class catch a miswired grouping: the wrong summary line goes high, or neither does. Writes to the masked-status offset and to unmapped offsets must leave the state untouched, and toggling the enable must gate only the interrupt line. An address decoder that aliased those offsets would corrupt the mask or clear status.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;

    localparam int EVT_W = 32;

    // Bit positions whose meaning a neighbouring sequencer decodes
    localparam int B_RSP_ERR    = 1;
    localparam int B_CMD_DONE   = 2;
    localparam int B_DATA_OVER  = 3;
    localparam int B_TX_REQ     = 4;
    localparam int B_RX_REQ     = 5;
    localparam int B_RSP_CRC    = 6;
    localparam int B_DATA_CRC   = 7;
    localparam int B_RSP_TMO    = 8;
    localparam int B_DATA_TMO   = 9;
    localparam int B_VOLT_DONE  = 10;
    localparam int B_FIFO_RUN   = 11;
    localparam int B_HW_LOCK    = 12;
    localparam int B_START_ERR  = 13;
    localparam int B_AUTO_DONE  = 14;
    localparam int B_END_ERR    = 15;
    localparam int B_SDIO       = 16;
    localparam int B_CARD_IN    = 30;
    localparam int B_CARD_OUT   = 31;

    localparam logic [EVT_W-1:0] IMPL_BITS =
        (32'h1 << B_RSP_ERR)   | (32'h1 << B_CMD_DONE)  | (32'h1 << B_DATA_OVER) |
        (32'h1 << B_TX_REQ)    | (32'h1 << B_RX_REQ)    | (32'h1 << B_RSP_CRC)   |
        (32'h1 << B_DATA_CRC)  | (32'h1 << B_RSP_TMO)   | (32'h1 << B_DATA_TMO)  |
        (32'h1 << B_VOLT_DONE) | (32'h1 << B_FIFO_RUN)  | (32'h1 << B_HW_LOCK)   |
        (32'h1 << B_START_ERR) | (32'h1 << B_AUTO_DONE) | (32'h1 << B_END_ERR)   |
        (32'h1 << B_SDIO)      | (32'h1 << B_CARD_IN)   | (32'h1 << B_CARD_OUT);

    localparam logic [EVT_W-1:0] FAIL_BITS =
        (32'h1 << B_RSP_ERR)  | (32'h1 << B_RSP_CRC)  | (32'h1 << B_DATA_CRC) |
        (32'h1 << B_RSP_TMO)  | (32'h1 << B_DATA_TMO) | (32'h1 << B_FIFO_RUN) |
        (32'h1 << B_HW_LOCK)  | (32'h1 << B_START_ERR)| (32'h1 << B_END_ERR);

    localparam logic [EVT_W-1:0] FINISH_BITS =
        (32'h1 << B_CMD_DONE) | (32'h1 << B_DATA_OVER) |
        (32'h1 << B_VOLT_DONE)| (32'h1 << B_AUTO_DONE);

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_MASK,
        RSEL_MASKED,
        RSEL_RAW
    } rsel_e;

    typedef struct packed {
        logic [EVT_W-1:0] raw;
        logic [EVT_W-1:0] mask;
    } irq_state_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import card_irq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int OFF_MASK    = 'h30,
    parameter int OFF_MASKED  = 'h34,
    parameter int OFF_RAW     = 'h38
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [EVT_W-1:0]  raw_q,
    input  logic [EVT_W-1:0]  mask_q,
    input  logic [EVT_W-1:0]  masked,
    output logic              wr_mask,
    output logic              wr_raw,
    output logic [EVT_W-1:0]  rdata
);
    rsel_e rsel;

    always_comb begin
        if (bus_addr == ADDR_W'(OFF_MASK))
            rsel = RSEL_MASK;
        else if (bus_addr == ADDR_W'(OFF_MASKED))
            rsel = RSEL_MASKED;
        else if (bus_addr == ADDR_W'(OFF_RAW))
            rsel = RSEL_RAW;
        else
            rsel = RSEL_NONE;
    end

    assign wr_mask = bus_wr && (rsel == RSEL_MASK);
    assign wr_raw  = bus_wr && (rsel == RSEL_RAW);

    always_comb begin
        unique case (rsel)
            RSEL_MASK:   rdata = mask_q;
            RSEL_MASKED: rdata = masked;
            RSEL_RAW:    rdata = raw_q;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import card_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             wr_mask,
    input  logic             wr_raw,
    input  logic [EVT_W-1:0] wdata,
    output logic [EVT_W-1:0] raw_q,
    output logic [EVT_W-1:0] mask_q
);
    irq_state_t       st_d, st_q;
    logic [EVT_W-1:0] clr_bits;
    logic [EVT_W-1:0] raw_nxt;

    assign clr_bits = wr_raw ? wdata : '0;

    // One sticky cell per implemented position, a constant zero elsewhere
    for (genvar i = 0; i < EVT_W; i++) begin : g_cell
        if (IMPL_BITS[i]) begin : g_live
            assign raw_nxt[i] = evt_i[i] | (st_q.raw[i] & ~clr_bits[i]);
        end else begin : g_tied
            assign raw_nxt[i] = 1'b0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.raw = raw_nxt;
        if (wr_mask)
            st_d.mask = wdata & IMPL_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import card_irq_pkg::*;
(
    input  logic [EVT_W-1:0] raw_q,
    input  logic [EVT_W-1:0] mask_q,
    input  logic             irq_en,
    output logic [EVT_W-1:0] masked,
    output logic             irq_o,
    output logic             err_sum_o,
    output logic             done_sum_o
);
    assign masked     = raw_q & mask_q;
    assign irq_o      = irq_en && (|masked);
    assign err_sum_o  = |(masked & FAIL_BITS);
    assign done_sum_o = |(masked & FINISH_BITS);
endmodule

// File: rtl/card_irq_status.sv
module card_irq_status
    import card_irq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int OFF_MASK   = 'h30,
    parameter int OFF_MASKED = 'h34,
    parameter int OFF_RAW    = 'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic [31:0]       evt_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              err_sum_o,
    output logic              done_sum_o
);
    logic             wr_mask, wr_raw;
    logic [EVT_W-1:0] raw_q, mask_q, masked;

    irq_bus_decode #(
        .ADDR_W     (ADDR_W),
        .OFF_MASK   (OFF_MASK),
        .OFF_MASKED (OFF_MASKED),
        .OFF_RAW    (OFF_RAW)
    ) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .raw_q    (raw_q),
        .mask_q   (mask_q),
        .masked   (masked),
        .wr_mask  (wr_mask),
        .wr_raw   (wr_raw),
        .rdata    (bus_rdata)
    );

    irq_status_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .wr_mask (wr_mask),
        .wr_raw  (wr_raw),
        .wdata   (bus_wdata),
        .raw_q   (raw_q),
        .mask_q  (mask_q)
    );

    irq_summary u_sum (
        .raw_q      (raw_q),
        .mask_q     (mask_q),
        .irq_en     (irq_en),
        .masked     (masked),
        .irq_o      (irq_o),
        .err_sum_o  (err_sum_o),
        .done_sum_o (done_sum_o)
    );
endmodule

// File: rtl/card_irq_checker.sv
module card_irq_checker
    import card_irq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int OFF_MASK = 'h30,
    parameter int OFF_RAW  = 'h38
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en,
    input logic [31:0]       evt_i,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_o,
    input logic              err_sum_o,
    input logic              done_sum_o,
    input logic [31:0]       raw_q,
    input logic [31:0]       mask_q
);
    logic [31:0] clr_req;
    logic [31:0] hit;
    assign clr_req = (bus_wr && bus_addr == ADDR_W'(OFF_RAW)) ? bus_wdata : '0;
    assign hit     = clr_req & evt_i & IMPL_BITS;

    // R1: state is empty one edge into reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && mask_q == '0));

    // R2 / R3: a set bit only drops when a clearing write named it
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_q) & ~$past(clr_req) & ~raw_q) == '0));

    // R2: an implemented event is captured on the next edge
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_i) & IMPL_BITS & ~raw_q) == '0));

    // R4: event beats a same-cycle clear
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((raw_q & $past(hit)) == $past(hit)));

    // R6: mask write lands on the next edge
    a_r6_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_MASK)) |=> (mask_q == ($past(bus_wdata) & IMPL_BITS)));

    // R7: enable gates the interrupt line
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);

    // R8: a failure summary with enable implies an interrupt
    a_r8_err_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sum_o && irq_en) |-> irq_o);

    // R9: a completion summary with enable implies an interrupt
    a_r9_done_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (done_sum_o && irq_en) |-> irq_o);

    // R10: unimplemented positions stay clear
    a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q | mask_q) & ~IMPL_BITS) == '0);
endmodule

bind card_irq_status card_irq_checker #(
    .ADDR_W   (ADDR_W),
    .OFF_MASK (OFF_MASK),
    .OFF_RAW  (OFF_RAW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .evt_i      (evt_i),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_o      (irq_o),
    .err_sum_o  (err_sum_o),
    .done_sum_o (done_sum_o),
    .raw_q      (raw_q),
    .mask_q     (mask_q)
);

// File: tb/sim_card_irq_status.sv
`timescale 1ns/1ps
module sim_card_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_en = 1'b0;
    logic [31:0] evt_i = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, err_sum_o, done_sum_o;

    int n_chk = 0;
    int n_fail = 0;
    int wdog = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    card_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .evt_i(evt_i),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .err_sum_o(err_sum_o),
        .done_sum_o(done_sum_o)
    );

    // Reference model built from the requirement text
    int live_pos[18] = '{1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,30,31};
    int fail_pos[9]  = '{1,6,7,8,9,11,12,13,15};
    int fin_pos[4]   = '{2,3,10,14};
    logic [31:0] m_live, m_fail, m_fin;
    logic [31:0] m_raw = '0, m_mask = '0;

    initial begin
        m_live = '0; m_fail = '0; m_fin = '0;
        foreach (live_pos[k]) m_live[live_pos[k]] = 1'b1;
        foreach (fail_pos[k]) m_fail[fail_pos[k]] = 1'b1;
        foreach (fin_pos[k])  m_fin[fin_pos[k]]   = 1'b1;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_raw  <= '0;
            m_mask <= '0;
        end else begin
            logic [31:0] nr;
            nr = m_raw;
            if (bus_wr && bus_addr == 8'h38) nr = nr & ~bus_wdata;
            nr = nr | (evt_i & m_live);
            m_raw <= nr;
            if (bus_wr && bus_addr == 8'h30) m_mask <= bus_wdata & m_live;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [31:0] msk, exp_rd;
        string rq;
        msk = m_raw & m_mask;
        case (bus_addr)
            8'h30:   begin exp_rd = m_mask; rq = "R6 mask read"; end
            8'h34:   begin exp_rd = msk;    rq = "R5 masked read"; end
            8'h38:   begin exp_rd = m_raw;  rq = "R2/R3 raw read"; end
            default: begin exp_rd = '0;     rq = "R11 unmapped read"; end
        endcase
        check(bus_rdata == exp_rd, rq, bus_rdata, exp_rd);
        check(irq_o == (irq_en && msk != 0), "R7 irq", 32'(irq_o), 32'(irq_en && msk != 0));
        check(err_sum_o == ((msk & m_fail) != 0), "R8 err summary", 32'(err_sum_o), 32'((msk & m_fail) != 0));
        check(done_sum_o == ((msk & m_fin) != 0), "R9 done summary", 32'(done_sum_o), 32'((msk & m_fin) != 0));
    endtask

    // One bus cycle: compare state at the falling edge, then drive new inputs
    task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d, input logic [31:0] e);
        @(negedge clk);
        compare_all();
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_i = e;
    endtask

    task automatic settle_read(input logic [7:0] a);
        cyc(1'b0, a, '0, '0);
        @(posedge clk);
        #1;
    endtask

    logic [31:0] lfsr = 32'h1ACE_B00C;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        // R1: reset state
        bus_addr = 8'h38;
        repeat (3) @(posedge clk);
        #1;
        check(bus_rdata == 0, "R1 raw in reset", bus_rdata, 0);
        check(!irq_o && !err_sum_o && !done_sum_o, "R1 outputs in reset", {irq_o, err_sum_o, done_sum_o}, 0);
        bus_addr = 8'h30;
        #0.5;
        check(bus_rdata == 0, "R1 mask in reset", bus_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_en = 1'b1;

        // R2/R10: walk a pulse through every position, unmasked
        for (int b = 0; b < 32; b++) begin
            cyc(1'b0, 8'h38, '0, 32'h1 << b);
            cyc(1'b0, 8'h38, '0, '0);
            @(posedge clk); #1;
            check(bus_rdata[b] == m_live[b], m_live[b] ? "R2 sticky capture" : "R10 unimplemented stays 0",
                  32'(bus_rdata[b]), 32'(m_live[b]));
            cyc(1'b1, 8'h38, 32'hFFFF_FFFF, '0);
        end

        // R6: mask load with all ones reads back only implemented bits
        cyc(1'b1, 8'h30, 32'hFFFF_FFFF, '0);
        settle_read(8'h30);
        check(bus_rdata == 32'hC001_FFFE, "R6 mask implemented bits", bus_rdata, 32'hC001_FFFE);

        // R8: single failure event
        cyc(1'b0, 8'h34, '0, 32'h1 << 9);
        settle_read(8'h34);
        check(err_sum_o && !done_sum_o && irq_o, "R8 data timeout class", {err_sum_o, done_sum_o, irq_o}, 3'b101);
        cyc(1'b1, 8'h38, 32'h0000_FFFF, '0);

        // R9: single completion event, R7 enable toggle
        cyc(1'b0, 8'h34, '0, 32'h1 << 14);
        settle_read(8'h34);
        check(!err_sum_o && done_sum_o, "R9 auto done class", {err_sum_o, done_sum_o}, 2'b01);
        irq_en = 1'b0;
        #0.5;
        check(!irq_o, "R7 irq gated off", 32'(irq_o), 0);
        irq_en = 1'b1;
        #0.5;
        check(irq_o, "R7 irq enabled", 32'(irq_o), 1);

        // R3: partial clear keeps zero-written bits
        cyc(1'b0, 8'h38, '0, 32'hC000_0006);
        cyc(1'b1, 8'h38, 32'h0000_0004, '0);
        settle_read(8'h38);
        check(bus_rdata == 32'hC000_4002, "R3 partial clear", bus_rdata, 32'hC000_4002);
        cyc(1'b1, 8'h38, 32'h0000_FFFF, '0);
        settle_read(8'h38);
        check(bus_rdata == 32'hC000_0000, "R3 low-16 clear", bus_rdata, 32'hC000_0000);

        // R4: event and clear on the same bit in one cycle
        cyc(1'b0, 8'h38, '0, 32'h0000_0008);
        cyc(1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0000_0008);
        settle_read(8'h38);
        check(bus_rdata == 32'h0000_0008, "R4 event wins over clear", bus_rdata, 32'h0000_0008);

        // R11: writes to masked and unmapped offsets change nothing
        cyc(1'b1, 8'h34, 32'hFFFF_FFFF, '0);
        cyc(1'b1, 8'h3C, 32'h0000_0000, '0);
        cyc(1'b1, 8'h00, 32'hFFFF_FFFF, '0);
        settle_read(8'h38);
        check(bus_rdata == 32'h0000_0008, "R11 raw untouched", bus_rdata, 32'h0000_0008);
        settle_read(8'h30);
        check(bus_rdata == 32'hC001_FFFE, "R11 mask untouched", bus_rdata, 32'hC001_FFFE);
        settle_read(8'h3C);
        check(bus_rdata == 0, "R11 unmapped reads 0", bus_rdata, 0);

        // R5: masked read under a partial mask
        cyc(1'b1, 8'h30, 32'h0000_00F0, 32'h0000_0030);
        settle_read(8'h34);
        check(bus_rdata == 32'h0000_0030, "R5 masked subset", bus_rdata, 32'h0000_0030);

        // Mixed traffic against the model on every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            lfsr = nxt(lfsr);
            case (lfsr[2:0])
                3'd0, 3'd1: a = 8'h38;
                3'd2, 3'd3: a = 8'h34;
                3'd4:       a = 8'h30;
                3'd5:       a = 8'h3C;
                default:    a = 8'h00;
            endcase
            irq_en = (lfsr[7:4] != 4'd0);
            begin
                logic [31:0] d, e;
                d = nxt(lfsr);
                e = nxt(d) & nxt(nxt(d));
                lfsr = nxt(nxt(d));
                cyc(lfsr[9:8] == 2'b00, a, d, e);
            end
        end
        cyc(1'b0, 8'h38, '0, '0);
        @(negedge clk);
        compare_all();
        done = 1'b1;
    end

    always @(posedge clk) begin
        wdog <= wdog + 1;
        if (wdog > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", wdog);
            done = 1'b1;
        end
    end

    initial begin
        wait (done);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule